// File: doc/BRIEF.md
# I2C Master Transmit Controller

This block is a register-programmed I2C master that sends bytes to a slave. Software selects master transmit operation through a mode register. It then asks for a start condition and writes bytes into a transmit holding register. The first byte is the 7-bit slave address with the read/write bit. The block drives SCL and SDA as open-drain lines: an output enable pulls the line low, and the line value comes back on a sampled input. The slave's acknowledge is captured after every byte. When software asks for a stop condition, the block releases the bus.

Transmit data is double-buffered. The holding register can take the next byte while the current byte is still shifting out. Two separate flags report the state of the transmit path: one says the holding register has space, and the other says a byte has finished with nothing waiting behind it. Bus-busy status comes from start and stop conditions seen on the synchronized lines. A sticky flag records that a stop has reached the bus. The SCL timing is built from a parameterized quarter-period divider.

Top module: `i2cm_tx_ctrl`

## Requirements
- R1: After reset, SCL and SDA are released. The mode register (address 0: bit 0 transmit select, bit 1 master select) reads 0. The bus register (address 1: bit 0 bus busy) reads 0. The status register (address 2: bit 0 holding-empty, bit 1 transfer-end, bit 2 received acknowledge, bit 3 stop-seen) reads 0.
- R2: Writing the bus register with bit 0 = 1 and bit 1 (qualifier) = 0, while both mode bits are 1 and the bus is not busy, makes SDA fall while SCL is high. After that, bus busy reads 1.
- R3: A start request has no effect, and both lines stay released, in two cases: when it is written with qualifier = 1, or when the mode bits are not both 1.
- R4: Data bits leave MSB first. SDA changes while SCL is high only for a start or a stop.
- R5: The holding-empty flag sets when the held byte moves into the shifter. A write to the data register (address 3) clears it, so a second byte can be queued while the first one shifts.
- R6: The transfer-end flag sets when a byte and its acknowledge clock finish with no byte queued. It clears when the next byte enters the shifter, or when bit 1 of the status register is written with 0.
- R7: The received-acknowledge bit takes the SDA value seen during the ninth SCL high phase of each byte. 0 means acknowledged and 1 means not acknowledged. The master releases SDA during that clock.
- R8: After the acknowledge clock, SCL is held low until a byte is queued or a stop is requested.
- R9: Writing the bus register with bits 1:0 = 00 while the bus is held makes SDA rise while SCL is high. After that, stop-seen reads 1 and bus busy reads 0.
- R10: Each SCL high phase of a data or acknowledge clock lasts 2 × QUARTER_CYC clock cycles.
- R11: Status bits clear only when written with 0. Writing 1 leaves them unchanged, and the acknowledge bit ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 mode, 1 bus, 2 status, 3 data) |
| reg_wdata | input | BYTE_W | Register write data |
| reg_rdata | output | BYTE_W | Register read data, combinational from reg_addr |
| scl_oe | output | 1 | Pulls SCL low when 1 |
| scl_in | input | 1 | Sampled SCL line |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| sda_in | input | 1 | Sampled SDA line |

## Verification
The hardest case to reach from the ports is a data write that arrives while a byte is already in the shifter. This case must show the holding-empty flag dropping while the transfer-end flag stays clear, and then both bytes coming out back to back. The bench reaches it by polling holding-empty right after the first byte is queued and writing the second byte as soon as the flag sets. A wire-level slave model rebuilds every byte from the SCL and SDA lines. It answers with an acknowledge or a no-acknowledge, chosen per byte from a table, and it times each SCL high phase.

// File: rtl/i2cm_pkg.sv
`timescale 1ns/1ps
package i2cm_pkg;

   typedef enum logic [2:0] {
      ENG_IDLE,
      ENG_START,
      ENG_HOLD,
      ENG_DATA,
      ENG_ACK,
      ENG_STOP
   } eng_state_t;

   localparam logic [1:0] REG_MODE = 2'd0;
   localparam logic [1:0] REG_BUS  = 2'd1;
   localparam logic [1:0] REG_STAT = 2'd2;
   localparam logic [1:0] REG_TXD  = 2'd3;

   localparam int ST_EMPTY = 0;
   localparam int ST_END   = 1;
   localparam int ST_ACK   = 2;
   localparam int ST_STOP  = 3;

endpackage

// File: rtl/i2cm_tick.sv
`timescale 1ns/1ps
module i2cm_tick #(
   parameter int QUARTER_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CNT_W = (QUARTER_CYC > 1) ? $clog2(QUARTER_CYC) : 1;

   logic [CNT_W-1:0] cnt_q;

   assign tick = (cnt_q == CNT_W'(QUARTER_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/i2cm_line_mon.sv
`timescale 1ns/1ps
module i2cm_line_mon #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic sda_s,
   output logic start_det,
   output logic stop_det,
   output logic bus_busy
);
   logic [SYNC_STAGES-1:0] scl_sh;
   logic [SYNC_STAGES-1:0] sda_sh;
   logic scl_s, scl_p, sda_p;

   generate
      if (SYNC_STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_sh <= '1;
               sda_sh <= '1;
            end else begin
               scl_sh <= scl_in;
               sda_sh <= sda_in;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_sh <= '1;
               sda_sh <= '1;
            end else begin
               scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_in};
               sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_in};
            end
         end
      end
   endgenerate

   assign scl_s = scl_sh[SYNC_STAGES-1];
   assign sda_s = sda_sh[SYNC_STAGES-1];

   assign start_det = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p    <= 1'b1;
         sda_p    <= 1'b1;
         bus_busy <= 1'b0;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
         if (start_det)     bus_busy <= 1'b1;
         else if (stop_det) bus_busy <= 1'b0;
      end
   end
endmodule

// File: rtl/i2cm_regs.sv
`timescale 1ns/1ps
module i2cm_regs
   import i2cm_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [BYTE_W-1:0] reg_wdata,
   output logic [BYTE_W-1:0] reg_rdata,
   input  logic              eng_idle,
   input  logic              load_pulse,
   input  logic              end_pulse,
   input  logic              ack_pulse,
   input  logic              ack_val,
   input  logic              stop_det,
   input  logic              bus_busy,
   output logic              start_req,
   output logic              stop_req,
   output logic              buf_full,
   output logic [BYTE_W-1:0] buf_data,
   output logic              tx_empty,
   output logic              tx_end,
   output logic              stop_seen
);
   logic mode_mst, mode_trs, ack_bit;
   logic wr_mode, wr_bus, wr_stat, wr_txd;

   assign wr_mode = reg_wr && (reg_addr == REG_MODE);
   assign wr_bus  = reg_wr && (reg_addr == REG_BUS);
   assign wr_stat = reg_wr && (reg_addr == REG_STAT);
   assign wr_txd  = reg_wr && (reg_addr == REG_TXD) && mode_mst && mode_trs;

   assign start_req = wr_bus && (reg_wdata[1:0] == 2'b01) && mode_mst && mode_trs
                      && !bus_busy && eng_idle;
   assign stop_req  = wr_bus && (reg_wdata[1:0] == 2'b00) && !eng_idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_mst  <= 1'b0;
         mode_trs  <= 1'b0;
         ack_bit   <= 1'b0;
         tx_empty  <= 1'b0;
         tx_end    <= 1'b0;
         stop_seen <= 1'b0;
         buf_full  <= 1'b0;
         buf_data  <= '0;
      end else begin
         if (wr_mode) begin
            mode_trs <= reg_wdata[0];
            mode_mst <= reg_wdata[1];
         end
         if (wr_stat && !reg_wdata[ST_EMPTY]) tx_empty <= 1'b0;
         if (load_pulse)                      tx_empty <= 1'b1;
         if (wr_txd)                          tx_empty <= 1'b0;

         if (wr_stat && !reg_wdata[ST_END]) tx_end <= 1'b0;
         if (load_pulse)                    tx_end <= 1'b0;
         if (end_pulse)                     tx_end <= 1'b1;

         if (wr_stat && !reg_wdata[ST_STOP]) stop_seen <= 1'b0;
         if (stop_det)                       stop_seen <= 1'b1;

         if (ack_pulse) ack_bit <= ack_val;

         if (load_pulse) buf_full <= 1'b0;
         if (wr_txd) begin
            buf_full <= 1'b1;
            buf_data <= reg_wdata;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         REG_MODE: reg_rdata[1:0] = {mode_mst, mode_trs};
         REG_BUS:  reg_rdata[0]   = bus_busy;
         REG_STAT: begin
            reg_rdata[ST_EMPTY] = tx_empty;
            reg_rdata[ST_END]   = tx_end;
            reg_rdata[ST_ACK]   = ack_bit;
            reg_rdata[ST_STOP]  = stop_seen;
         end
         default:  reg_rdata = buf_data;
      endcase
   end
endmodule

// File: rtl/i2cm_engine.sv
`timescale 1ns/1ps
module i2cm_engine
   import i2cm_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              start_req,
   input  logic              stop_req,
   input  logic              buf_full,
   input  logic [BYTE_W-1:0] buf_data,
   input  logic              sda_s,
   output logic              scl_drv,
   output logic              sda_drv,
   output logic              load_pulse,
   output logic              end_pulse,
   output logic              ack_pulse,
   output logic              eng_idle,
   output eng_state_t        state
);
   localparam int BIT_W = $clog2(BYTE_W);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

   logic [1:0]        phase;
   logic [BIT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] shifter;
   logic              start_pend, stop_pend;

   assign eng_idle   = (state == ENG_IDLE);
   assign load_pulse = tick && buf_full &&
                       ((state == ENG_HOLD) || ((state == ENG_ACK) && (phase == 2'd3)));
   assign end_pulse  = tick && !buf_full && (state == ENG_ACK) && (phase == 2'd3);
   assign ack_pulse  = tick && (state == ENG_ACK) && (phase == 2'd2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ENG_IDLE;
         phase      <= '0;
         bit_cnt    <= '0;
         shifter    <= '0;
         scl_drv    <= 1'b0;
         sda_drv    <= 1'b0;
         start_pend <= 1'b0;
         stop_pend  <= 1'b0;
      end else begin
         if (start_req) start_pend <= 1'b1;
         if (stop_req)  stop_pend  <= 1'b1;
         if (tick) begin
            case (state)
               ENG_IDLE: begin
                  scl_drv   <= 1'b0;
                  sda_drv   <= 1'b0;
                  phase     <= '0;
                  stop_pend <= 1'b0;
                  if (start_pend) begin
                     state      <= ENG_START;
                     start_pend <= 1'b0;
                  end
               end
               ENG_START: begin
                  phase <= phase + 2'd1;
                  if (phase == 2'd1) sda_drv <= 1'b1;
                  if (phase == 2'd3) begin
                     scl_drv <= 1'b1;
                     state   <= ENG_HOLD;
                  end
               end
               ENG_HOLD: begin
                  phase <= '0;
                  if (buf_full) begin
                     shifter <= buf_data;
                     bit_cnt <= '0;
                     state   <= ENG_DATA;
                  end else if (stop_pend) begin
                     state     <= ENG_STOP;
                     stop_pend <= 1'b0;
                  end
               end
               ENG_DATA: begin
                  phase <= phase + 2'd1;
                  case (phase)
                     2'd0: sda_drv <= ~shifter[BYTE_W-1];
                     2'd1: scl_drv <= 1'b0;
                     2'd3: begin
                        scl_drv <= 1'b1;
                        shifter <= {shifter[BYTE_W-2:0], 1'b0};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == LAST_BIT) state <= ENG_ACK;
                     end
                     default: ;
                  endcase
               end
               ENG_ACK: begin
                  phase <= phase + 2'd1;
                  case (phase)
                     2'd0: sda_drv <= 1'b0;
                     2'd1: scl_drv <= 1'b0;
                     2'd3: begin
                        scl_drv <= 1'b1;
                        if (buf_full) begin
                           shifter <= buf_data;
                           bit_cnt <= '0;
                           state   <= ENG_DATA;
                        end else begin
                           state <= ENG_HOLD;
                        end
                     end
                     default: ;
                  endcase
               end
               ENG_STOP: begin
                  phase <= phase + 2'd1;
                  case (phase)
                     2'd0: sda_drv <= 1'b1;
                     2'd1: scl_drv <= 1'b0;
                     2'd2: sda_drv <= 1'b0;
                     default: state <= ENG_IDLE;
                  endcase
               end
               default: state <= ENG_IDLE;
            endcase
         end
      end
   end

   logic unused_sda;
   assign unused_sda = sda_s;
endmodule

// File: rtl/i2cm_tx_ctrl.sv
`timescale 1ns/1ps
module i2cm_tx_ctrl
   import i2cm_pkg::*;
#(
   parameter int QUARTER_CYC = 4,
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [BYTE_W-1:0] reg_wdata,
   output logic [BYTE_W-1:0] reg_rdata,
   output logic              scl_oe,
   input  logic              scl_in,
   output logic              sda_oe,
   input  logic              sda_in
);
   if (QUARTER_CYC < SYNC_STAGES + 2) begin : g_chk_quarter
      $error("QUARTER_CYC must exceed the synchronizer latency by two cycles");
   end
   if (BYTE_W < 4) begin : g_chk_byte
      $error("BYTE_W must hold the four status bits");
   end
   if (SYNC_STAGES < 1) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 1");
   end

   logic       tick;
   logic       sda_s, start_det, stop_det, bus_busy;
   logic       start_req, stop_req, buf_full;
   logic [BYTE_W-1:0] buf_data;
   logic       tx_empty, tx_end, stop_seen;
   logic       load_pulse, end_pulse, ack_pulse, eng_idle;
   eng_state_t eng_state;

   i2cm_tick #(.QUARTER_CYC(QUARTER_CYC)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   i2cm_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
      .bus_busy(bus_busy)
   );

   i2cm_regs #(.BYTE_W(BYTE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_idle(eng_idle),
      .load_pulse(load_pulse), .end_pulse(end_pulse), .ack_pulse(ack_pulse),
      .ack_val(sda_s), .stop_det(stop_det), .bus_busy(bus_busy),
      .start_req(start_req), .stop_req(stop_req), .buf_full(buf_full),
      .buf_data(buf_data), .tx_empty(tx_empty), .tx_end(tx_end),
      .stop_seen(stop_seen)
   );

   i2cm_engine #(.BYTE_W(BYTE_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start_req(start_req),
      .stop_req(stop_req), .buf_full(buf_full), .buf_data(buf_data),
      .sda_s(sda_s), .scl_drv(scl_oe), .sda_drv(sda_oe),
      .load_pulse(load_pulse), .end_pulse(end_pulse), .ack_pulse(ack_pulse),
      .eng_idle(eng_idle), .state(eng_state)
   );
endmodule

// File: rtl/i2cm_tx_ctrl_chk.sv
`timescale 1ns/1ps
module i2cm_tx_ctrl_chk
   import i2cm_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       reg_wr,
   input logic [1:0] reg_addr,
   input logic       scl_oe,
   input logic       sda_oe,
   input eng_state_t eng_state,
   input logic       load_pulse,
   input logic       tx_empty,
   input logic       tx_end,
   input logic       start_det,
   input logic       stop_det,
   input logic       bus_busy,
   input logic       stop_seen
);
   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_state == ENG_IDLE) |-> (!scl_oe && !sda_oe)); // R1

   AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> bus_busy); // R2

   AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_oe) && !scl_oe && !$past(scl_oe))
      |-> ((eng_state == ENG_START) || (eng_state == ENG_STOP))); // R4

   AST_EMPTY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (load_pulse && !(reg_wr && (reg_addr == REG_TXD))) |=> tx_empty); // R5

   AST_END_CLEARED_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load_pulse |=> !tx_end); // R6

   AST_ACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      ((eng_state == ENG_ACK) && !scl_oe) |-> !sda_oe); // R7

   AST_HOLD_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_state == ENG_HOLD) |-> scl_oe); // R8

   AST_STOP_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (stop_seen && !bus_busy)); // R9
endmodule

bind i2cm_tx_ctrl i2cm_tx_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .scl_oe(scl_oe), .sda_oe(sda_oe), .eng_state(eng_state),
   .load_pulse(load_pulse), .tx_empty(tx_empty), .tx_end(tx_end),
   .start_det(start_det), .stop_det(stop_det), .bus_busy(bus_busy),
   .stop_seen(stop_seen)
);

// File: tb/i2cm_tx_ctrl_tb_top.sv
`timescale 1ns/1ps
module i2cm_tx_ctrl_tb_top;
   localparam int QC = 4;
   localparam int BW = 8;
   localparam logic [1:0] A_MODE = 2'd0, A_BUS = 2'd1, A_STAT = 2'd2, A_TXD = 2'd3;
   localparam int NVEC = 4;
   // bit 8: slave answers with no-acknowledge; bits 7:0: byte sent
   localparam logic [8:0] VEC [NVEC] = '{9'h0A6, 9'h05A, 9'h181, 9'h0FF};

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [1:0]    reg_addr = '0;
   logic [BW-1:0] reg_wdata = '0;
   logic [BW-1:0] reg_rdata;
   logic          scl_oe, sda_oe;
   logic          slv_drv = 1'b0;
   wire           scl_line = !scl_oe;
   wire           sda_line = !(sda_oe || slv_drv);

   i2cm_tx_ctrl #(.QUARTER_CYC(QC), .BYTE_W(BW)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_oe(scl_oe),
      .scl_in(scl_line), .sda_oe(sda_oe), .sda_in(sda_line)
   );

   int n_chk = 0, n_bad = 0;

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // wire-level slave model
   logic   prev_scl = 1'b1, prev_sda = 1'b1;
   logic   ack_low = 1'b1;
   logic [7:0] sh = '0;
   logic [7:0] got_log [16];
   int     bit_n = 0, got_cnt = 0, starts = 0, stops = 0, hi_bad = 0, hi_cnt = 0;
   realtime t_rise = 0.0;

   always @(scl_line or sda_line) begin
      if (prev_scl && scl_line && (sda_line != prev_sda)) begin
         if (!sda_line) begin
            starts++;
            bit_n = 0;
         end else begin
            stops++;
         end
      end
      if (!prev_scl && scl_line) begin
         t_rise = $realtime;
         if (bit_n < 8) sh = {sh[6:0], sda_line};
         bit_n++;
      end
      if (prev_scl && !scl_line && bit_n > 0) begin
         hi_cnt++;
         if (($realtime - t_rise) < (2.0*QC*4.0 - 0.5) ||
             ($realtime - t_rise) > (2.0*QC*4.0 + 0.5)) hi_bad++;
         if (bit_n == 8) slv_drv = ack_low;
         else if (bit_n == 9) begin
            slv_drv = 1'b0;
            got_log[got_cnt % 16] = sh;
            got_cnt++;
            bit_n = 0;
         end
      end
      prev_scl = scl_line;
      prev_sda = sda_line;
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic poll(input logic [1:0] a, input int b, input logic v, output bit ok);
      logic [7:0] d;
      ok = 1'b0;
      for (int i = 0; i < 3000; i++) begin
         rd(a, d);
         if (d[b] == v) begin
            ok = 1'b1;
            break;
         end
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=expired expected=done");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] d;
      bit ok;
      int c0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(A_MODE, d); check("R1 mode", d, 0);
      rd(A_BUS, d);  check("R1 bus", d, 0);
      rd(A_STAT, d); check("R1 status", d, 0);
      check("R1 lines", {scl_oe, sda_oe}, 0);

      // R3 start without both mode bits
      wr(A_BUS, 8'h01);
      repeat (100) @(negedge clk);
      check("R3 no-mode start", starts, 0);
      rd(A_BUS, d); check("R3 no-mode busy", d[0], 0);

      // R3 start with qualifier set
      wr(A_MODE, 8'h03);
      wr(A_BUS, 8'h03);
      repeat (100) @(negedge clk);
      check("R3 qualifier start", starts, 0);
      check("R3 qualifier lines", {scl_oe, sda_oe}, 0);

      // R2 start
      wr(A_BUS, 8'h01);
      poll(A_BUS, 0, 1'b1, ok);
      check("R2 busy set", ok, 1);
      check("R2 start on wire", starts, 1);

      // table walk: R4 byte order, R7 ack, R5 empty, R6 end
      for (int i = 0; i < NVEC; i++) begin
         ack_low = !VEC[i][8];
         wr(A_STAT, 8'hFD);
         wr(A_TXD, VEC[i][7:0]);
         poll(A_STAT, 1, 1'b1, ok);
         check("R6 end after byte", ok, 1);
         check("R4 byte MSB first", got_log[(got_cnt - 1) % 16], VEC[i][7:0]);
         check("R4 byte count", got_cnt, i + 1);
         rd(A_STAT, d);
         check("R7 ack bit", d[2], VEC[i][8]);
         check("R5 empty after move", d[0], 1);
      end

      // R8 SCL held low while nothing queued
      c0 = got_cnt;
      repeat (200) @(negedge clk);
      check("R8 scl held", scl_line, 0);
      check("R8 no extra byte", got_cnt, c0);

      // R11 writing ones leaves status unchanged
      rd(A_STAT, d); check("R11 status before", d, 8'h03);
      wr(A_STAT, 8'hFF);
      rd(A_STAT, d); check("R11 status after", d, 8'h03);

      // R5/R6 double buffering
      ack_low = 1'b1;
      c0 = got_cnt;
      wr(A_TXD, 8'h3C);
      poll(A_STAT, 0, 1'b1, ok);
      check("R5 empty after move", ok, 1);
      rd(A_STAT, d); check("R6 end cleared by load", d[1], 0);
      wr(A_TXD, 8'hC3);
      rd(A_STAT, d); check("R5 empty cleared by write", d[0], 0);
      check("R5 first byte still shifting", got_cnt, c0);
      poll(A_STAT, 1, 1'b1, ok);
      check("R6 end after pair", ok, 1);
      check("R5 pair count", got_cnt, c0 + 2);
      check("R5 pair first", got_log[c0 % 16], 8'h3C);
      check("R5 pair second", got_log[(c0 + 1) % 16], 8'hC3);

      // R6 clear by writing 0
      wr(A_STAT, 8'hFD);
      rd(A_STAT, d);
      check("R6 end cleared", d[1], 0);
      check("R11 empty kept", d[0], 1);

      // R9 stop
      wr(A_STAT, 8'hF7);
      wr(A_BUS, 8'h00);
      poll(A_STAT, 3, 1'b1, ok);
      check("R9 stop seen", ok, 1);
      check("R9 stop on wire", stops, 1);
      rd(A_BUS, d); check("R9 busy cleared", d[0], 0);
      repeat (20) @(negedge clk);
      check("R9 lines released", {scl_oe, sda_oe}, 0);
      check("R4 no stray start", starts, 1);

      // R10 SCL high time
      check("R10 high phases seen", hi_cnt > 0, 1);
      check("R10 high phase length", hi_bad, 0);

      // leave master transmit
      wr(A_MODE, 8'h00);
      wr(A_STAT, 8'hFE);
      rd(A_MODE, d); check("R1 mode cleared", d, 0);
      rd(A_STAT, d); check("R11 empty cleared by zero", d[0], 0);

      summary();
      $finish;
   end
endmodule